// File: doc/BRIEF.md
# Programmable Clock Output Divider Channel

This block is one output channel of a clock generator. It divides a fast source clock by a programmable integer from 1 to 127. It is modelled synchronously: everything runs on the fast clock `clk`. The fast clock counts as one source tick in every cycle. Slower sources (a reference signal or a neighbouring channel's output) are level signals sampled on `clk`. Each of their rising edges counts as one source tick. The channel output `divOut` is a level waveform on the `clk` grid.

The channel adds four controls around the counter:
- a start delay after the divider leaves reset;
- an enable that starts and stops the output only at period boundaries, so no runt pulses appear;
- optional gating that keeps the divider in reset until lock is present and restarts it on the lock edge;
- bypass muxing that puts the reference before or after the divider, plus a cascade select so that one channel can count another channel's output.

Chip integration ties several instances together. The output of one instance can feed the `cascadeIn` of the next.

Top module: `pdiv_channel`

## Requirements
- R1: While `rst_n` is low, or while the divider is held in reset, the divider output is low. The next period starts from its first tick.
- R2: For an effective divide value D of 2 or more, the divider output repeats every D source ticks. It is high for the first floor(D/2) ticks of each period and low for the rest. The output is registered: the level set by the tick sampled at edge k is visible after edge k.
- R3: For D = 1 the divider output follows the selected source level, registered once. The fast source is seen as a constant 1. A `divVal` of 0 is treated as 1.
- R4: With start delay S (0 to 7), ticks are ignored for the first S cycles after the divider leaves reset. With the fast source, the first high level appears after the edge S cycles after the first non-reset edge.
- R5: Dropping `chanEn` stops the output only at the next period boundary, after the current period completes. A stopped output stays low.
- R6: Raising `chanEn` while stopped starts a fresh period at the next source tick, beginning with the high phase.
- R7: With `resetOnLock` = 1, the divider is held in reset while `lockIn` is low. It is reset once more on the rising edge of `lockIn` and then runs with the start delay. With `resetOnLock` = 0, `lockIn` has no effect.
- R8: With `bypassGoN` = 0 and `bypassPre` = 1, the divider counts rising edges of `refPulse` instead of the fast clock. With `bypassGoN` = 1, `bypassPre` has no effect.
- R9: With `bypassGoN` = 0 and `bypassPost` = 1, `divOut` equals `refPulse` combinationally, including during reset. Otherwise `divOut` is the divider output.
- R10: With `cascadeSel` = 1, the divider counts rising edges of `cascadeIn`. This selection takes priority over the pre-divider bypass.
- R11: A level source yields one tick per rising edge. The output does not change between ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock; all state advances on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| refPulse | input | 1 | Reference clock level, sampled on `clk` |
| cascadeIn | input | 1 | Output level of another channel, for cascading |
| lockIn | input | 1 | Lock indication |
| divVal | input | 7 | Divide value, 1 to 127 (0 is treated as 1) |
| startDly | input | 3 | Start delay in fast cycles after leaving reset |
| chanEn | input | 1 | Output enable, honoured at period boundaries |
| resetOnLock | input | 1 | Hold the divider in reset until lock, and restart it on the lock edge |
| bypassPre | input | 1 | Count the reference instead of the fast clock |
| bypassPost | input | 1 | Drive the reference straight to the output |
| bypassGoN | input | 1 | Active-low qualifier for both bypass bits |
| cascadeSel | input | 1 | Count `cascadeIn` instead of the fast clock or the reference |
| divOut | output | 1 | Channel output |

## Verification
A wrong phase count or half-period threshold moves the output by a fixed number of cycles. This shows as a wrong duty or period within one period of D fast cycles. A start-delay counter that is off by one shifts every later edge, so the first wrong sample comes within eight cycles of reset release. A run flag or edge-detect register that is wrong shows up differently: a runt pulse after a stop, a missing restart, or a doubled tick rate on a level source. Each of these appears within the first two periods after the stimulus that exposes it.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic clr;   // divider held in reset this cycle
    logic live;  // start delay elapsed, ticks may be counted
  } pdivStrobe_t;

  typedef enum logic [1:0] {
    SRC_FAST = 2'd0,
    SRC_REF  = 2'd1,
    SRC_CASC = 2'd2
  } pdivSrc_t;

endpackage

// File: rtl/pdiv_ctrl.sv
module pdiv_ctrl
  import pdiv_pkg::*;
#(
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lockIn,
  input  logic             resetOnLock,
  input  logic [DLY_W-1:0] startDly,
  output pdivStrobe_t      stb
);

  logic             lockPrev;
  logic             lockRise;
  logic             clrNow;
  logic [DLY_W-1:0] dlyCnt;
  logic             started;
  logic             dlyDone;

  assign lockRise = lockIn & ~lockPrev;
  assign clrNow   = resetOnLock & (~lockIn | lockRise);
  assign dlyDone  = (dlyCnt == startDly);

  always_comb begin
    stb.clr  = clrNow;
    stb.live = (started | dlyDone) & ~clrNow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lockPrev <= 1'b0;
      dlyCnt   <= '0;
      started  <= 1'b0;
    end else begin
      lockPrev <= lockIn;
      if (clrNow) begin
        dlyCnt  <= '0;
        started <= 1'b0;
      end else if (!started) begin
        if (dlyDone) started <= 1'b1;
        else         dlyCnt  <= dlyCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pdiv_datapath.sv
module pdiv_datapath
  import pdiv_pkg::*;
#(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pdivStrobe_t      stb,
  input  logic             refPulse,
  input  logic             cascadeIn,
  input  logic [DIV_W-1:0] divVal,
  input  logic             chanEn,
  input  logic             selPre,
  input  logic             selCascade,
  input  logic             selPost,
  output logic             divQ,
  output logic             divOut
);

  pdivSrc_t         srcKind;
  logic             srcLevel;
  logic             srcPrev;
  logic             srcTick;
  logic [DIV_W-1:0] effDiv;
  logic [DIV_W-1:0] halfCnt;
  logic [DIV_W-1:0] cnt;
  logic             atBound;
  logic             lastPh;
  logic             runReg;
  logic             runNow;
  logic             advance;
  logic             unitDiv;
  logic             outReg;

  always_comb begin
    if (selCascade)  srcKind = SRC_CASC;
    else if (selPre) srcKind = SRC_REF;
    else             srcKind = SRC_FAST;
    unique case (srcKind)
      SRC_REF:  srcLevel = refPulse;
      SRC_CASC: srcLevel = cascadeIn;
      default:  srcLevel = 1'b1;
    endcase
  end

  assign srcTick = (srcKind == SRC_FAST) ? 1'b1 : (srcLevel & ~srcPrev);
  assign effDiv  = (divVal == '0) ? DIV_W'(1) : divVal;
  assign unitDiv = (effDiv == DIV_W'(1));
  assign halfCnt = effDiv >> 1;
  assign atBound = (cnt == '0);
  assign lastPh  = (cnt >= effDiv - DIV_W'(1));
  assign runNow  = atBound ? chanEn : runReg;
  assign advance = stb.live & srcTick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srcPrev <= 1'b0;
      cnt     <= '0;
      runReg  <= 1'b0;
      outReg  <= 1'b0;
    end else begin
      srcPrev <= srcLevel;
      if (stb.clr) begin
        cnt    <= '0;
        runReg <= 1'b0;
        outReg <= 1'b0;
      end else if (unitDiv) begin
        cnt    <= '0;
        runReg <= 1'b0;
        if (stb.live) outReg <= chanEn & srcLevel;
      end else if (advance) begin
        runReg <= runNow;
        if (runNow) begin
          outReg <= (cnt < halfCnt);
          cnt    <= lastPh ? '0 : cnt + 1'b1;
        end else begin
          outReg <= 1'b0;
          cnt    <= '0;
        end
      end
    end
  end

  assign divQ   = outReg;
  assign divOut = selPost ? refPulse : outReg;

endmodule

// File: rtl/pdiv_channel.sv
module pdiv_channel
  import pdiv_pkg::*;
#(
  parameter int DIV_W = 7,
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             refPulse,
  input  logic             cascadeIn,
  input  logic             lockIn,
  input  logic [DIV_W-1:0] divVal,
  input  logic [DLY_W-1:0] startDly,
  input  logic             chanEn,
  input  logic             resetOnLock,
  input  logic             bypassPre,
  input  logic             bypassPost,
  input  logic             bypassGoN,
  input  logic             cascadeSel,
  output logic             divOut
);

  pdivStrobe_t stb;
  logic        divQ;
  logic        selPre;
  logic        selPost;

  assign selPre  = ~bypassGoN & bypassPre;
  assign selPost = ~bypassGoN & bypassPost;

  pdiv_ctrl #(.DLY_W(DLY_W)) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .lockIn      (lockIn),
    .resetOnLock (resetOnLock),
    .startDly    (startDly),
    .stb         (stb)
  );

  pdiv_datapath #(.DIV_W(DIV_W)) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb        (stb),
    .refPulse   (refPulse),
    .cascadeIn  (cascadeIn),
    .divVal     (divVal),
    .chanEn     (chanEn),
    .selPre     (selPre),
    .selCascade (cascadeSel),
    .selPost    (selPost),
    .divQ       (divQ),
    .divOut     (divOut)
  );

endmodule

// File: rtl/pdiv_channel_chk.sv
module pdiv_channel_chk (
  input logic clk,
  input logic rst_n,
  input logic lockIn,
  input logic resetOnLock,
  input logic chanEn,
  input logic stbClr,
  input logic divQ,
  input logic divOut,
  input logic refPulse,
  input logic bypassPost,
  input logic bypassGoN
);

  // R1: a cycle spent in divider reset leaves the output low
  p_clear_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stbClr |=> !divQ);

  // R7: lock gating keeps the divider output low
  p_lock_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (resetOnLock && !lockIn) |=> !divQ);

  // R5: once low with the enable dropped, the output does not rise
  p_park_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!divQ && !chanEn) |=> !divQ);

  // R9: outside post-bypass the port carries the divider output
  p_post_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bypassGoN || !bypassPost) |-> (divOut == divQ));

endmodule

bind pdiv_channel pdiv_channel_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .lockIn      (lockIn),
  .resetOnLock (resetOnLock),
  .chanEn      (chanEn),
  .stbClr      (stb.clr),
  .divQ        (divQ),
  .divOut      (divOut),
  .refPulse    (refPulse),
  .bypassPost  (bypassPost),
  .bypassGoN   (bypassGoN)
);

// File: tb/pdiv_channel_tb_top.sv
`timescale 1ns/1ps
module pdiv_channel_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       refPulse = 1'b0;
  logic       cascadeIn = 1'b0;
  logic       lockIn = 1'b0;
  logic [6:0] divVal = 7'd4;
  logic [2:0] startDly = 3'd0;
  logic       chanEn = 1'b1;
  logic       resetOnLock = 1'b0;
  logic       bypassPre = 1'b0;
  logic       bypassPost = 1'b0;
  logic       bypassGoN = 1'b1;
  logic       cascadeSel = 1'b0;
  logic       divOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pdiv_channel dut_i (
    .clk(clk), .rst_n(rst_n), .refPulse(refPulse), .cascadeIn(cascadeIn),
    .lockIn(lockIn), .divVal(divVal), .startDly(startDly), .chanEn(chanEn),
    .resetOnLock(resetOnLock), .bypassPre(bypassPre), .bypassPost(bypassPost),
    .bypassGoN(bypassGoN), .cascadeSel(cascadeSel), .divOut(divOut)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: divOut=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Expected divider output after edge k for the fast source
  function automatic logic expFast(input int k, input int d, input int s);
    int dd;
    dd = (d == 0) ? 1 : d;
    if (k < s) return 1'b0;
    if (dd == 1) return 1'b1;
    return ((k - s) % dd) < (dd / 2);
  endfunction

  task automatic setDefaults();
    refPulse = 0; cascadeIn = 0; lockIn = 0; divVal = 7'd4; startDly = 0;
    chanEn = 1; resetOnLock = 0; bypassPre = 0; bypassPost = 0;
    bypassGoN = 1; cascadeSel = 0;
  endtask

  task automatic enterReset();
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
  endtask

  // Release at a falling edge; the next rising edge is edge 0
  task automatic leaveReset();
    rst_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state and R9 bypass during reset
    setDefaults();
    enterReset();
    chk("R1", divOut, 1'b0);
    refPulse = 1; bypassPost = 1; #1;
    chk("R9", divOut, 1'b0);
    bypassGoN = 0; #1;
    chk("R9", divOut, 1'b1);
    refPulse = 0; #1;
    chk("R9", divOut, 1'b0);
    setDefaults();

    // Sweep of divide value and start delay, fast source; lock low is ignored (R7)
    for (int d = 0; d <= 9; d++) begin
      for (int s = 0; s <= 7; s++) begin
        enterReset();
        divVal = 7'(d); startDly = 3'(s); lockIn = 0; resetOnLock = 0;
        leaveReset();
        for (int k = 0; k < 24; k++) begin
          @(negedge clk);
          if (d <= 1)     chk("R3", divOut, expFast(k, d, s));
          else if (k < s) chk("R4", divOut, expFast(k, d, s));
          else            chk("R2/R7", divOut, expFast(k, d, s));
        end
      end
    end

    // R5 stop at boundary, R6 restart with fresh period
    begin
      int b;
      int m;
      enterReset();
      setDefaults(); divVal = 7'd6;
      leaveReset();
      for (int k = 0; k <= 7; k++) begin
        @(negedge clk);
        chk("R2", divOut, expFast(k, 6, 0));
      end
      chanEn = 0;              // first seen at edge 8
      b = 12;                  // next boundary edge after 7
      for (int k = 8; k < 24; k++) begin
        @(negedge clk);
        chk("R5", divOut, (k < b) ? expFast(k, 6, 0) : 1'b0);
      end
      m = 23;
      chanEn = 1;              // first seen at edge m+1
      for (int j = 0; j < 14; j++) begin
        @(negedge clk);
        chk("R6", divOut, ((j % 6) < 3));
      end
    end

    // R7 reset-on-lock
    enterReset();
    setDefaults(); divVal = 7'd4; startDly = 3'd2; resetOnLock = 1;
    leaveReset();
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk("R7", divOut, 1'b0);
    end
    lockIn = 1;                // rising edge seen at the next edge: reset again
    @(negedge clk);
    chk("R7", divOut, 1'b0);
    for (int j = 0; j < 12; j++) begin
      @(negedge clk);
      chk("R7", divOut, expFast(j, 4, 2));
    end
    lockIn = 0;
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      chk("R7", divOut, 1'b0);
    end

    // R8 and R11: reference counted through pre-bypass, one rise every 3 cycles
    enterReset();
    setDefaults(); divVal = 7'd3; bypassGoN = 0; bypassPre = 1;
    refPulse = 1;
    leaveReset();
    for (int e = 0; e < 27; e++) begin
      @(negedge clk);
      chk("R8/R11", divOut, (((e / 3) % 3) < 1));
      refPulse = (((e + 1) % 3) == 0);
    end

    // R8: pre-bypass bit ignored while the go signal is high
    enterReset();
    setDefaults(); divVal = 7'd3; bypassGoN = 1; bypassPre = 1;
    refPulse = 1;
    leaveReset();
    for (int e = 0; e < 12; e++) begin
      @(negedge clk);
      chk("R8", divOut, expFast(e, 3, 0));
      refPulse = (((e + 1) % 3) == 0);
    end

    // R10: cascade input wins over pre-bypass; cascade rises every 4 cycles
    enterReset();
    setDefaults(); divVal = 7'd2; bypassGoN = 0; bypassPre = 1; cascadeSel = 1;
    cascadeIn = 1;
    leaveReset();
    for (int e = 0; e < 24; e++) begin
      @(negedge clk);
      chk("R10", divOut, (((e / 4) % 2) < 1));
      cascadeIn = (((e + 1) % 4) < 2);
    end

    // R9 while running: post-bypass follows the reference at once
    bypassPost = 1;
    refPulse = 1; #1;
    chk("R9", divOut, 1'b1);
    refPulse = 0; #1;
    chk("R9", divOut, 1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule